// File: doc/BRIEF.md
# Micro-op Dispatch Stage

This block admits decoded instructions into an out-of-order back end. Each clock it offers up to `LANES` instructions in program order. Every instruction states its micro-op count, its destination count per register file, a dependency-breaking flag, a zero-latency flag and a mask of which source operands are implicit. The block spends a per-clock budget of `WIDTH` dispatch slots, measured in micro-ops. It also checks that the retire buffer has enough free entries and that each physical register file has enough free registers. It reports which lanes were taken, how much retire space and how many registers to claim, which source operands need read-after-write tracking, and a stall code for the first lane it refused.

An instruction with more micro-ops than `WIDTH` is legal, but only when the whole budget is still untouched in that clock. It then uses every slot, and its excess micro-ops are held as a carry-over. While the carry-over is nonzero, nothing new is admitted. The carry-over drains by `WIDTH` each clock. The retire buffer and rename tables live outside the block: it only sees their free counts and emits claim amounts.

Top module: `dispatch_stage`

## Requirements
- R1: After reset the carry-over (`carry_left`) is zero, so the full budget of `WIDTH` slots is available in the first clock.
- R2: Lanes are considered in order; lane i is admitted only if every lane before it was admitted in the same clock. An instruction whose micro-op count fits the slots still unused in this clock (at most `WIDTH` in total) consumes that many slots.
- R3: An instruction with more than `WIDTH` micro-ops is admitted only when all `WIDTH` slots are still unused; it uses all remaining slots and `carry_left` becomes its count minus `WIDTH` in the next clock.
- R4: While `carry_left` is nonzero, no lane is admitted and a valid lane 0 gets stall code 3. Each clock, `carry_left` drops by `WIDTH`, saturating at zero.
- R5: A lane is refused with stall code 1 when its micro-op count exceeds the retire entries left after earlier admitted lanes. `rob_req_uops` equals the total micro-ops admitted in the clock, and `rob_req_valid` is high when any lane is admitted.
- R6: A lane is refused with stall code 2 when, in any register file f, its destination count exceeds the registers left after earlier admitted lanes. `reg_req` field f (bits f*PRFW upward) equals the registers claimed in file f.
- R7: An instruction that is both zero-latency and dependency-breaking claims no physical registers and is never refused for lack of them.
- R8: For an admitted lane i, `raw_track` bit i*NSRC+s is 1 when source s is implicit or the instruction is not dependency-breaking; bits for refused or invalid lanes are 0.
- R9: Stall codes are 0 none, 1 retire buffer full, 2 register file full, 3 dispatch width exhausted. When a lane fails several checks, width wins over retire, and retire wins over register. The code comes from the first valid lane refused. It is 0 when every valid lane reached is admitted or when the lane reached is invalid, which also stops later lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Lane holds an instruction |
| in_uops | input | LANES*UOPW | Micro-op count per lane |
| in_ndst | input | LANES*NRF*DSTW | Destination count per lane per register file, field (i*NRF+f) |
| in_zero_lat | input | LANES | Instruction has zero latency |
| in_dep_break | input | LANES | Instruction breaks dependencies |
| in_src_implicit | input | LANES*NSRC | Source operand is implicit, bit i*NSRC+s |
| rob_free | input | ROBW | Free retire buffer entries |
| prf_free | input | NRF*PRFW | Free physical registers per file |
| disp_accept | output | LANES | Lane admitted this clock |
| stall_code | output | 2 | Reason the first valid lane was refused |
| rob_req_valid | output | 1 | Retire slot reservation requested |
| rob_req_uops | output | ROBW | Retire entries to reserve |
| reg_req | output | NRF*PRFW | Registers to claim per file |
| raw_track | output | LANES*NSRC | Source operands needing dependency tracking |
| carry_left | output | UOPW | Pending carry-over micro-ops |

## Verification
The random stream mixes micro-op counts that fit, fill or overflow the width with tight free counts. This sets apart refusal for slots, retire space and registers, and it shows whether the in-order chain passes the reduced budget from one lane to the next. Directed cases hit the exact boundaries where free space equals the need and where it is one short. They also cover an oversize instruction draining its carry over several clocks, which separates "only at full width" from "whenever it fits". Further cases check a zero-latency dependency-breaking instruction against empty register files, and lanes that fail several checks at once, which fixes the order of stall codes.

// File: rtl/disp_pkg.sv
package disp_pkg;

    typedef enum logic [1:0] {
        STALL_NONE    = 2'd0,
        STALL_RETIRE  = 2'd1,
        STALL_REGFILE = 2'd2,
        STALL_WIDTH   = 2'd3
    } stall_e;

endpackage

// File: rtl/disp_lane.sv
module disp_lane
    import disp_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int NRF   = 2,
    parameter int UOPW  = 4,
    parameter int DSTW  = 2,
    parameter int ROBW  = 6,
    parameter int PRFW  = 5
) (
    input  logic                go_in,
    input  logic                valid,
    input  logic [UOPW-1:0]     uops,
    input  logic [NRF*DSTW-1:0] ndst,
    input  logic                zero_lat,
    input  logic                dep_break,
    input  logic [UOPW-1:0]     slots_in,
    input  logic [ROBW-1:0]     rob_in,
    input  logic [NRF*PRFW-1:0] prf_in,
    output logic                accept,
    output stall_e              stall,
    output logic [UOPW-1:0]     slots_out,
    output logic [ROBW-1:0]     rob_out,
    output logic [NRF*PRFW-1:0] prf_out,
    output logic [UOPW-1:0]     carry_out
);

    localparam logic [UOPW-1:0] W_U = UOPW'(WIDTH);

    logic           oversize;
    logic           width_ok;
    logic           rob_ok;
    logic           alloc;
    logic [NRF-1:0] busy;

    assign oversize = uops > W_U;
    assign width_ok = (slots_in != '0) &&
                      ((uops <= slots_in) || (oversize && slots_in == W_U));
    assign rob_ok   = ROBW'(uops) <= rob_in;
    // renaming removes zero-latency dependency breakers: no register needed
    assign alloc    = !(zero_lat && dep_break);
    assign accept   = go_in && valid && width_ok && rob_ok && (busy == '0);

    for (genvar f = 0; f < NRF; f++) begin : g_file
        logic [PRFW-1:0] need;
        assign need    = PRFW'(ndst[f*DSTW +: DSTW]);
        assign busy[f] = alloc && (need > prf_in[f*PRFW +: PRFW]);
        assign prf_out[f*PRFW +: PRFW] = (accept && alloc) ?
                                         prf_in[f*PRFW +: PRFW] - need :
                                         prf_in[f*PRFW +: PRFW];
    end

    always_comb begin
        stall = STALL_NONE;
        if (go_in && valid && !accept) begin
            if (!width_ok)    stall = STALL_WIDTH;
            else if (!rob_ok) stall = STALL_RETIRE;
            else              stall = STALL_REGFILE;
        end
    end

    assign slots_out = !accept ? slots_in : (oversize ? '0 : slots_in - uops);
    assign rob_out   = accept ? rob_in - ROBW'(uops) : rob_in;
    assign carry_out = (accept && oversize) ? uops - W_U : '0;

endmodule

// File: rtl/disp_raw_filter.sv
module disp_raw_filter #(
    parameter int NSRC = 3
) (
    input  logic            accept,
    input  logic            dep_break,
    input  logic [NSRC-1:0] implicit_src,
    output logic [NSRC-1:0] track
);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // explicit sources of a dependency breaker need no tracking
        assign track[s] = accept && (implicit_src[s] || !dep_break);
    end

endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage
    import disp_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int LANES = 2,
    parameter int NRF   = 2,
    parameter int NSRC  = 3,
    parameter int UOPW  = 4,
    parameter int DSTW  = 2,
    parameter int ROBW  = 6,
    parameter int PRFW  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          in_valid,
    input  logic [LANES*UOPW-1:0]     in_uops,
    input  logic [LANES*NRF*DSTW-1:0] in_ndst,
    input  logic [LANES-1:0]          in_zero_lat,
    input  logic [LANES-1:0]          in_dep_break,
    input  logic [LANES*NSRC-1:0]     in_src_implicit,
    input  logic [ROBW-1:0]           rob_free,
    input  logic [NRF*PRFW-1:0]       prf_free,
    output logic [LANES-1:0]          disp_accept,
    output logic [1:0]                stall_code,
    output logic                      rob_req_valid,
    output logic [ROBW-1:0]           rob_req_uops,
    output logic [NRF*PRFW-1:0]       reg_req,
    output logic [LANES*NSRC-1:0]     raw_track,
    output logic [UOPW-1:0]           carry_left
);

    localparam logic [UOPW-1:0]  W_U = UOPW'(WIDTH);
    localparam logic [LANES-1:0] ONE_L = LANES'(1);

    typedef struct packed {
        logic [UOPW-1:0] carry;
    } state_t;

    state_t st_d, st_q;

    logic [UOPW-1:0]     slots_c [LANES+1];
    logic [ROBW-1:0]     rob_c   [LANES+1];
    logic [NRF*PRFW-1:0] prf_c   [LANES+1];
    logic [LANES:0]      go_c;
    logic [UOPW-1:0]     carry_l [LANES];
    stall_e              stall_l [LANES];

    assign slots_c[0] = (st_q.carry == '0) ? W_U : '0;
    assign rob_c[0]   = rob_free;
    assign prf_c[0]   = prf_free;
    assign go_c[0]    = 1'b1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        disp_lane #(
            .WIDTH(WIDTH), .NRF(NRF), .UOPW(UOPW),
            .DSTW(DSTW), .ROBW(ROBW), .PRFW(PRFW)
        ) u_lane (
            .go_in     (go_c[i]),
            .valid     (in_valid[i]),
            .uops      (in_uops[i*UOPW +: UOPW]),
            .ndst      (in_ndst[i*NRF*DSTW +: NRF*DSTW]),
            .zero_lat  (in_zero_lat[i]),
            .dep_break (in_dep_break[i]),
            .slots_in  (slots_c[i]),
            .rob_in    (rob_c[i]),
            .prf_in    (prf_c[i]),
            .accept    (disp_accept[i]),
            .stall     (stall_l[i]),
            .slots_out (slots_c[i+1]),
            .rob_out   (rob_c[i+1]),
            .prf_out   (prf_c[i+1]),
            .carry_out (carry_l[i])
        );
        assign go_c[i+1] = disp_accept[i];

        disp_raw_filter #(.NSRC(NSRC)) u_raw (
            .accept       (disp_accept[i]),
            .dep_break    (in_dep_break[i]),
            .implicit_src (in_src_implicit[i*NSRC +: NSRC]),
            .track        (raw_track[i*NSRC +: NSRC])
        );
    end

    for (genvar f = 0; f < NRF; f++) begin : g_req
        assign reg_req[f*PRFW +: PRFW] = prf_free[f*PRFW +: PRFW] -
                                         prf_c[LANES][f*PRFW +: PRFW];
    end

    logic [UOPW-1:0] new_carry;
    logic [1:0]      stall_any;

    always_comb begin
        new_carry = '0;
        stall_any = '0;
        for (int i = 0; i < LANES; i++) begin
            new_carry = new_carry | carry_l[i];
            stall_any = stall_any | stall_l[i];
        end
        st_d = st_q;
        if (st_q.carry != '0)
            st_d.carry = (st_q.carry > W_U) ? st_q.carry - W_U : '0;
        else
            st_d.carry = new_carry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall_code    = stall_any;
    assign rob_req_uops  = rob_free - rob_c[LANES];
    assign rob_req_valid = disp_accept != '0;
    assign carry_left    = st_q.carry;

    // R4
    carry_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_left != '0) |-> (disp_accept == '0));

    // R4
    carry_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_left > W_U) |=> (carry_left == $past(carry_left) - W_U));

    // R5
    rob_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rob_req_uops <= rob_free);

    // R2
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_accept & (disp_accept + ONE_L)) == '0);

    // R9
    stall_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_code != 2'd0) |-> ((disp_accept & in_valid) != in_valid));

    // R8
    raw_only_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_accept == '0) |-> (raw_track == '0));

endmodule

// File: tb/sim_dispatch_stage.sv
`timescale 1ns/100ps
module sim_dispatch_stage;

    localparam int WIDTH = 4, LANES = 2, NRF = 2, NSRC = 3;
    localparam int UOPW = 4, DSTW = 2, ROBW = 6, PRFW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [LANES-1:0]          in_valid;
    logic [LANES*UOPW-1:0]     in_uops;
    logic [LANES*NRF*DSTW-1:0] in_ndst;
    logic [LANES-1:0]          in_zero_lat, in_dep_break;
    logic [LANES*NSRC-1:0]     in_src_implicit;
    logic [ROBW-1:0]           rob_free;
    logic [NRF*PRFW-1:0]       prf_free;
    logic [LANES-1:0]          disp_accept;
    logic [1:0]                stall_code;
    logic                      rob_req_valid;
    logic [ROBW-1:0]           rob_req_uops;
    logic [NRF*PRFW-1:0]       reg_req;
    logic [LANES*NSRC-1:0]     raw_track;
    logic [UOPW-1:0]           carry_left;

    dispatch_stage #(
        .WIDTH(WIDTH), .LANES(LANES), .NRF(NRF), .NSRC(NSRC),
        .UOPW(UOPW), .DSTW(DSTW), .ROBW(ROBW), .PRFW(PRFW)
    ) u0 (.*);

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // stimulus fields
    int v[LANES], u[LANES], zl[LANES], db[LANES], imp[LANES];
    int nd[LANES][NRF];
    int rf_free[NRF];
    int rb_free;
    int m_carry = 0;

    // expected values
    int e_acc, e_stall, e_rob, e_raw, e_next;
    int e_reg[NRF];

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive();
        for (int i = 0; i < LANES; i++) begin
            in_valid[i]     = v[i][0];
            in_uops[i*UOPW +: UOPW] = UOPW'(u[i]);
            in_zero_lat[i]  = zl[i][0];
            in_dep_break[i] = db[i][0];
            in_src_implicit[i*NSRC +: NSRC] = NSRC'(imp[i]);
            for (int f = 0; f < NRF; f++)
                in_ndst[(i*NRF+f)*DSTW +: DSTW] = DSTW'(nd[i][f]);
        end
        rob_free = ROBW'(rb_free);
        for (int f = 0; f < NRF; f++) prf_free[f*PRFW +: PRFW] = PRFW'(rf_free[f]);
    endtask

    task automatic model();
        int slots, rob, go, wok, rok, pok, alloc, newc;
        int prf[NRF];
        slots = (m_carry == 0) ? WIDTH : 0;
        rob = rb_free; go = 1; newc = 0;
        e_acc = 0; e_stall = 0; e_raw = 0;
        for (int f = 0; f < NRF; f++) prf[f] = rf_free[f];
        for (int i = 0; i < LANES; i++) begin
            if (go == 1 && v[i] == 1) begin
                wok = (slots != 0) && (u[i] <= slots || (u[i] > WIDTH && slots == WIDTH));
                rok = u[i] <= rob;
                alloc = !(zl[i] == 1 && db[i] == 1);
                pok = 1;
                for (int f = 0; f < NRF; f++) if (alloc && nd[i][f] > prf[f]) pok = 0;
                if (wok && rok && pok) begin
                    e_acc |= (1 << i);
                    if (u[i] > WIDTH) begin newc = u[i] - WIDTH; slots = 0; end
                    else slots -= u[i];
                    rob -= u[i];
                    if (alloc) for (int f = 0; f < NRF; f++) prf[f] -= nd[i][f];
                    e_raw |= ((db[i] == 1) ? imp[i] : ((1 << NSRC) - 1)) << (i*NSRC);
                end else begin
                    e_stall = !wok ? 3 : (!rok ? 1 : 2);
                    go = 0;
                end
            end else go = 0;
        end
        e_rob = rb_free - rob;
        for (int f = 0; f < NRF; f++) e_reg[f] = rf_free[f] - prf[f];
        if (m_carry != 0) e_next = (m_carry > WIDTH) ? m_carry - WIDTH : 0;
        else e_next = newc;
    endtask

    // inputs applied at the falling edge; outputs compared 1 ns later
    task automatic step(string tag);
        drive();
        #1;
        model();
        check({tag, " R1/R4 carry_left"}, int'(carry_left), m_carry);
        check({tag, " R2/R3 disp_accept"}, int'(disp_accept), e_acc);
        check({tag, " R9 stall_code"}, int'(stall_code), e_stall);
        check({tag, " R5 rob_req_uops"}, int'(rob_req_uops), e_rob);
        check({tag, " R5 rob_req_valid"}, int'(rob_req_valid), int'(e_acc != 0));
        for (int f = 0; f < NRF; f++)
            check({tag, " R6/R7 reg_req"}, int'(reg_req[f*PRFW +: PRFW]), e_reg[f]);
        check({tag, " R8 raw_track"}, int'(raw_track), e_raw);
        @(posedge clk);
        m_carry = e_next;
        @(negedge clk);
    endtask

    task automatic clear();
        for (int i = 0; i < LANES; i++) begin
            v[i] = 0; u[i] = 1; zl[i] = 0; db[i] = 0; imp[i] = 0;
            for (int f = 0; f < NRF; f++) nd[i][f] = 0;
        end
        rb_free = 31;
        for (int f = 0; f < NRF; f++) rf_free[f] = 15;
    endtask

    initial begin
        clear();
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 carry after reset", int'(carry_left), 0);
        step("R1 idle");

        // R2: two lanes fit
        clear(); v[0] = 1; v[1] = 1; u[0] = 2; u[1] = 2; step("R2 fit");
        // R2/R9: second lane exceeds remaining slots
        u[0] = 3; u[1] = 2; step("R2 overflow lane1");
        // R2: invalid lane 0 blocks lane 1
        v[0] = 0; step("R2 hole");
        // R3/R4: oversize at full width, then drain
        clear(); v[0] = 1; v[1] = 1; u[0] = 13; u[1] = 1; step("R3 oversize");
        check("R3 carry set", int'(carry_left), 9);
        step("R4 drain 1");
        step("R4 drain 2");
        step("R4 drain 3");
        check("R4 carry clear", int'(carry_left), 0);
        // R3: oversize in lane 1 after lane 0 used slots
        u[0] = 1; u[1] = 6; step("R3 oversize not full");
        // R5: retire boundary
        clear(); v[0] = 1; v[1] = 1; u[0] = 2; u[1] = 2; rb_free = 4; step("R5 exact");
        rb_free = 3; step("R5 one short");
        // R6: register boundary
        clear(); v[0] = 1; v[1] = 1; nd[0][1] = 2; nd[1][1] = 1; rf_free[1] = 3; step("R6 exact");
        rf_free[1] = 2; step("R6 one short");
        // R7: zero-latency dependency breaker with empty files
        clear(); v[0] = 1; zl[0] = 1; db[0] = 1; nd[0][0] = 3; nd[0][1] = 3; imp[0] = 5;
        rf_free[0] = 0; rf_free[1] = 0; step("R7 no alloc");
        zl[0] = 0; step("R7 dep-break only");
        // R8: explicit sources dropped only for dependency breakers
        clear(); v[0] = 1; v[1] = 1; db[0] = 1; imp[0] = 2; imp[1] = 4; step("R8 mix");
        // R9: width beats retire beats register
        clear(); v[0] = 1; v[1] = 1; u[0] = 1; u[1] = 4; rb_free = 1; rf_free[0] = 0;
        nd[1][0] = 1; step("R9 width first");
        u[1] = 3; u[0] = 1; rb_free = 2; step("R9 retire before reg");

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < LANES; i++) begin
                v[i]  = ($urandom % 8 != 0) ? 1 : 0;
                u[i]  = 1 + $urandom % 7;
                zl[i] = $urandom % 3 == 0 ? 1 : 0;
                db[i] = $urandom % 3 == 0 ? 1 : 0;
                imp[i] = $urandom % 8;
                for (int f = 0; f < NRF; f++) nd[i][f] = $urandom % 4;
            end
            rb_free = $urandom % 14;
            for (int f = 0; f < NRF; f++) rf_free[f] = $urandom % 6;
            step("random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule